// File: doc/BRIEF.md
# Multi-channel interrupt multiplexer

This block takes a bank of level-sensitive interrupt request lines and fans them out to several independent output channels. Every channel watches the whole shared bank through its own enable mask, so software can steer any source to any channel, or to several channels at once. A channel's output is high while at least one enabled source is high, and it falls again once the enabled sources are all low.

Software reaches the block over a plain single-cycle register bus with a byte address, write data, a write strobe, a read strobe and a read data return. Every channel has a mask register and a read-only pending register in its own 64-byte window. The bus has no back-pressure: there is no valid/ready pair, every strobe is accepted in the cycle it is presented, and read data returns in the next cycle. Source lines are asynchronous to the block clock and pass through a synchronizer before any other logic sees them.

Top module: `irq_fanout_top`

## Requirements
- R1: There are 8 channels, each with one output. With the matching mask bit set, a rising source drives the channel output high on the third rising clock edge after the source changes (two synchronizer flops plus one output register).
- R2: The mask register of channel c sits at byte address 0x10 + 0x40*c. Bit k set lets source k reach channel c. A write replaces the whole register, and a read returns the last value written.
- R3: The pending register of channel c sits at byte address 0x20 + 0x40*c. Bit k reads as the synchronized source k ANDed with mask bit k, and several bits can be set at once.
- R4: Sources are level-sensitive. The output stays high for as long as an enabled source stays high, and it falls on the third rising edge after the last enabled source goes low.
- R5: A synchronous active-low reset clears every mask register, the synchronizer and the read data, and it drives every channel output low.
- R6: A write to a pending register has no effect. The pending and mask values that are read afterwards are unchanged.
- R7: A read of any offset in a channel window other than 0x10 or 0x20 returns zero. A write to such an offset changes no register.
- R8: Read data is valid in the cycle after the read strobe and holds until the next read.
- R9: One source that is enabled in several channels raises every one of those channel outputs, and it leaves the other channels low.
- R10: Clearing a mask bit while its source is high drops the channel output on the rising edge after the edge that takes the write, if no other enabled source is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 32 | Level-sensitive interrupt sources, asynchronous |
| addr_i | input | 9 | Register byte address |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read data, registered |
| irq_o | output | 8 | One interrupt output per channel |

## Verification
The bench measures the exact edge on which an output rises after a source change, and the edge on which it falls after a mask bit is cleared. A design with one synchronizer flop too many or too few, or with an unregistered output, misses those edges by one cycle. It writes all ones to a pending register and to unmapped offsets, and then reads the neighbouring registers back. A decoder that aliases offsets would corrupt a mask, and one that reads out a stale value would return data instead of zero. It also steers one source into channels 0 and 7 at once and runs random masks and source patterns against a bench model. A channel index that is decoded with the wrong stride, or a shared mask, shows up as an output on the wrong channel.

// File: rtl/irq_fanout_pkg.sv
package irq_fanout_pkg;
  // Register kind selected by the offset inside a channel window
  typedef enum logic [1:0] {
    REG_NONE    = 2'd0,
    REG_MASK    = 2'd1,
    REG_PENDING = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_fanout_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int ADDR_W      = 9,
  parameter int CH_STRIDE   = 64,
  parameter int MASK_OFS    = 16,
  parameter int PENDING_OFS = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NUM_CH-1:0] ch_hit_o,
  output reg_kind_e         kind_o
);
  localparam int OFS_W = $clog2(CH_STRIDE);
  localparam int IDX_W = ADDR_W - OFS_W;

  logic [OFS_W-1:0] ofs;
  logic [IDX_W-1:0] idx;

  assign ofs = addr_i[OFS_W-1:0];
  assign idx = addr_i[ADDR_W-1:OFS_W];

  always_comb begin
    if (ofs == OFS_W'(MASK_OFS))         kind_o = REG_MASK;
    else if (ofs == OFS_W'(PENDING_OFS)) kind_o = REG_PENDING;
    else                                 kind_o = REG_NONE;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hit
    assign ch_hit_o[c] = (idx == IDX_W'(c)) && (kind_o != REG_NONE);
  end
endmodule

// File: rtl/irq_channel.sv
module irq_channel #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr_i,
  input  logic [NUM_SRC-1:0] mask_data_i,
  input  logic [NUM_SRC-1:0] src_sync_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic               irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)         mask_q <= '0;
    else if (mask_wr_i) mask_q <= mask_data_i;
  end

  assign pend_o = src_sync_i & mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pend_o;
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;

  // R6
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr_i |=> $stable(mask_q));

  // R4
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o == '0) |=> !irq_o);

  // R1
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o != '0) |=> irq_o);
endmodule

// File: rtl/irq_fanout_top.sv
module irq_fanout_top
  import irq_fanout_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_SRC     = 32,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter int CH_STRIDE   = 64,
  parameter int MASK_OFS    = 16,
  parameter int PENDING_OFS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_en_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               rd_en_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic [NUM_CH-1:0]  irq_o
);
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_CH-1:0]  ch_hit;
  reg_kind_e          kind;
  logic [NUM_SRC-1:0] mask_all [NUM_CH];
  logic [NUM_SRC-1:0] pend_all [NUM_CH];
  logic [DATA_W-1:0]  rd_data_d;
  logic [DATA_W-1:0]  rd_data_q;

  irq_src_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (src_i),
    .sync_o  (src_sync)
  );

  irq_reg_decode #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_STRIDE(CH_STRIDE),
    .MASK_OFS(MASK_OFS), .PENDING_OFS(PENDING_OFS)
  ) u_decode (
    .addr_i   (addr_i),
    .ch_hit_o (ch_hit),
    .kind_o   (kind)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic mask_wr;
    assign mask_wr = wr_en_i && ch_hit[c] && (kind == REG_MASK);

    irq_channel #(.NUM_SRC(NUM_SRC)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .mask_wr_i   (mask_wr),
      .mask_data_i (wr_data_i[NUM_SRC-1:0]),
      .src_sync_i  (src_sync),
      .mask_o      (mask_all[c]),
      .pend_o      (pend_all[c]),
      .irq_o       (irq_o[c])
    );
  end

  always_comb begin
    rd_data_d = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_hit[c] && kind == REG_MASK)    rd_data_d = rd_data_d | DATA_W'(mask_all[c]);
      if (ch_hit[c] && kind == REG_PENDING) rd_data_d = rd_data_d | DATA_W'(pend_all[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data_q <= '0;
    else if (rd_en_i) rd_data_q <= rd_data_d;
  end

  assign rd_data_o = rd_data_q;

  // R5
  rst_irq_low_chk: assert property (@(posedge clk)
    !rst_n |=> (irq_o == '0));

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));

  // R7
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && ch_hit == '0) |=> (rd_data_o == '0));
endmodule

// File: tb/test_irq_fanout_top.sv
module test_irq_fanout_top;
  localparam int NCH = 8;
  localparam int NSRC = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [8:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [7:0]  irq;

  int checks = 0;
  int failures = 0;
  logic [31:0] mask_m [NCH];

  always #5 clk = ~clk;

  irq_fanout_top i_irq_fanout_top (
    .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic int mask_addr(int c);
    return 16 + 64 * c;
  endfunction

  function automatic int pend_addr(int c);
    return 32 + 64 * c;
  endfunction

  function automatic logic [7:0] exp_irq(logic [31:0] s);
    logic [7:0] r;
    for (int c = 0; c < NCH; c++) r[c] = |(s & mask_m[c]);
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    addr = 9'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    addr = 9'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_mask(int c, logic [31:0] d);
    bus_write(mask_addr(c), d);
    mask_m[c] = d;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int c = 0; c < NCH; c++) mask_m[c] = '0;
    repeat (4) @(negedge clk);
    check(irq == 8'h00, "R5 outputs low in reset", 32'(irq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: all masks clear after reset
    for (int c = 0; c < NCH; c++) begin
      bus_read(mask_addr(c), d);
      check(d == 32'h0, "R5 mask clear after reset", d, 32'h0);
    end

    // R2: mask write and readback at the channel stride
    set_mask(3, 32'hA5A5_0F0F);
    bus_read(32'hD0, d);
    check(d == 32'hA5A5_0F0F, "R2 mask readback ch3", d, 32'hA5A5_0F0F);
    bus_read(mask_addr(2), d);
    check(d == 32'h0, "R2 neighbour mask untouched", d, 32'h0);

    // R1: rise latency of three edges
    set_mask(3, 32'h1);
    src = 32'h1;
    repeat (2) @(negedge clk);
    check(irq[3] == 1'b0, "R1 output not yet high after two edges", 32'(irq[3]), 32'h0);
    @(negedge clk);
    check(irq[3] == 1'b1, "R1 output high on third edge", 32'(irq[3]), 32'h1);
    check(irq == 8'h08, "R1 only ch3 raised", 32'(irq), 32'h08);

    // R4: level held, then release
    repeat (5) @(negedge clk);
    check(irq[3] == 1'b1, "R4 output held while source high", 32'(irq[3]), 32'h1);
    src = 32'h0;
    repeat (2) @(negedge clk);
    check(irq[3] == 1'b1, "R4 output still high two edges after release", 32'(irq[3]), 32'h1);
    @(negedge clk);
    check(irq[3] == 1'b0, "R4 output low third edge after release", 32'(irq[3]), 32'h0);

    // R10: clearing a mask bit drops the output one edge later
    src = 32'h1;
    settle();
    bus_write(mask_addr(3), 32'h0);
    mask_m[3] = '0;
    check(irq[3] == 1'b1, "R10 output high right after mask write", 32'(irq[3]), 32'h1);
    @(negedge clk);
    check(irq[3] == 1'b0, "R10 output low one edge after mask write", 32'(irq[3]), 32'h0);
    src = 32'h0;

    // R9: one source into two channels
    set_mask(0, 32'h20);
    set_mask(7, 32'h20);
    src = 32'h20;
    settle();
    check(irq == 8'h81, "R9 source 5 to ch0 and ch7", 32'(irq), 32'h81);

    // R3: pending with several bits
    set_mask(0, 32'hFF);
    src = 32'h0000_0F0A;
    settle();
    bus_read(pend_addr(0), d);
    check(d == 32'h0A, "R3 pending ch0 multi-bit", d, 32'h0A);
    bus_read(pend_addr(7), d);
    check(d == 32'h0, "R3 pending ch7 masked out", d, 32'h0);

    // R6: writes to pending ignored
    bus_write(pend_addr(0), 32'hFFFF_FFFF);
    bus_read(pend_addr(0), d);
    check(d == 32'h0A, "R6 pending unchanged after write", d, 32'h0A);
    bus_read(mask_addr(0), d);
    check(d == 32'hFF, "R6 mask unchanged after pending write", d, 32'hFF);

    // R7: unmapped offsets
    bus_read(64 * 2 + 0, d);
    check(d == 32'h0, "R7 offset 0x00 reads zero", d, 32'h0);
    bus_read(64 * 0 + 20, d);
    check(d == 32'h0, "R7 offset 0x14 reads zero", d, 32'h0);
    bus_write(64 * 0 + 24, 32'hFFFF_FFFF);
    bus_read(mask_addr(0), d);
    check(d == 32'hFF, "R7 unmapped write leaves mask", d, 32'hFF);

    // R8: read data valid after strobe and held
    bus_read(mask_addr(7), d);
    check(d == 32'h20, "R8 read data after strobe", d, 32'h20);
    repeat (3) @(negedge clk);
    check(rd_data == 32'h20, "R8 read data held", rd_data, 32'h20);

    // Random stimulus against the model (R1, R2, R3)
    for (int it = 0; it < 200; it++) begin
      int c;
      c = int'($urandom_range(NCH - 1));
      if ($urandom_range(1) == 1) set_mask(c, $urandom());
      if ($urandom_range(3) == 0) src = 32'h0;
      else src = $urandom() & $urandom();
      settle();
      check(irq == exp_irq(src), "R1 random outputs", 32'(irq), 32'(exp_irq(src)));
      c = int'($urandom_range(NCH - 1));
      bus_read(pend_addr(c), d);
      check(d == (src & mask_m[c]), "R3 random pending", d, src & mask_m[c]);
      bus_read(mask_addr(c), d);
      check(d == mask_m[c], "R2 random mask readback", d, mask_m[c]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule